// File: doc/BRIEF.md
# Differential thermometer-code requantizer

This block is the digital back end of a differential flash quantizer. Two comparator banks each deliver a thermometer vector; the block turns each into a signed count, takes their difference so that any shift common to both sides cancels, and then halves the difference back to the level count of one side. Halving is exact for even differences. For odd differences a ±1 switching term is added first, so the result is always an integer and the rounding error stays uncorrelated with the signal.

Two rounding policies are offered through a mode pin. In the white policy the sign of the ±1 term is taken directly from a pseudo-random bit. In the shaped policy successive nonzero terms alternate in sign, which pushes the rounding error towards high frequencies; the first sign after reset is taken from the pseudo-random bit. The random bit comes from a linear feedback shift register that is seeded at reset and steps once per accepted sample. The result is registered and appears one clock after the valid strobe.

Top module: `tcode_requant`

## Requirements
- R1: While rst_n is low at a rising edge, the block clears y_out to 0 and y_vld to 0, forgets any shaped-sign history and loads the generator from seed.
- R2: Each side's value is the number of ones in its comparator vector minus NCOMP/2 (range -16..+16 by default); the bit positions of the ones do not matter, so a vector with bubbles gives the same value as a clean code with the same number of ones.
- R3: With diff = value(comp_p) - value(comp_n), an even diff gives y_out = diff/2 exactly, in either mode, and the generator bit is not used.
- R4: In white mode (shape_en = 0) an odd diff gives y_out = (diff + s)/2 where s = +1 if the generator's bit 0 is 1 and s = -1 if it is 0.
- R5: In shaped mode (shape_en = 1) an odd diff uses s equal to minus the previous shaped-mode s; the first shaped odd sample since reset takes s from generator bit 0 as in R4.
- R6: y_out always lies in -NCOMP/2..+NCOMP/2, and 2*y_out differs from the accepted diff by at most 1.
- R7: A sample taken with valid_in high at a rising edge appears on y_out with y_vld high after that edge; with valid_in low, y_vld is 0 after the edge and y_out keeps its value.
- R8: The generator is 16 bits wide, shifts left once per accepted sample with the new bit 0 equal to the XOR of bits 15, 13, 12 and 10, and a zero seed is replaced by 1, so its state is never zero.
- R9: Odd samples in white mode leave the shaped-sign history unchanged, so the next shaped odd sample alternates against the last shaped one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Sample strobe for comp_p, comp_n and shape_en |
| shape_en | input | 1 | 0 = white rounding sign, 1 = alternating (shaped) sign |
| seed | input | 16 | Generator start state, loaded during reset |
| comp_p | input | NCOMP | Positive-side comparator vector |
| comp_n | input | NCOMP | Negative-side comparator vector |
| y_out | output | YW (7) | Requantized signed code, two's complement |
| y_vld | output | 1 | High for one cycle after each accepted sample |

## Verification
On every cycle the assertions hold the output inside its range and within one half-step of the accepted difference, require even differences to halve exactly, keep the output still when no sample is accepted, tie the valid flag to the strobe, and keep the generator state away from zero. Which sign is chosen for an odd difference, the alternation across runs of shaped samples, the independence of the shaped history from white-mode samples, and the zero-seed replacement can only be shown by the bench, which steps its own model of the generator and the sign history alongside the design and compares each result.

// File: rtl/tr_pkg.sv
// Shared types for the differential thermometer-code requantizer.
// Assumes nothing beyond IEEE 1800-2017.
package tr_pkg;
    // Rounding sign policy for odd differences.
    typedef enum logic {
        RND_WHITE  = 1'b0,
        RND_SHAPED = 1'b1
    } rnd_mode_e;
endpackage

// File: rtl/tr_bank_count.sv
// Converts one comparator vector into a signed value: ones count minus
// NCOMP/2. Assumes nothing about the bit order (bubbles are tolerated).
module tr_bank_count #(
    parameter int NCOMP = 32,
    parameter int SW    = $clog2(NCOMP + 1) + 1
) (
    input  logic [NCOMP-1:0]     therm,
    output logic signed [SW-1:0] value
);
    localparam int CNTW = $clog2(NCOMP + 1);
    localparam logic [SW-1:0] HALF = SW'(NCOMP / 2);

    logic [CNTW-1:0] ones;

    // Population count of the comparator outputs.
    always_comb begin
        ones = '0;
        for (int i = 0; i < NCOMP; i++) begin
            ones = ones + CNTW'(therm[i]);
        end
    end

    // Offset the count to centre it on zero.
    always_comb begin
        value = $signed(SW'(ones) - HALF);
    end
endmodule

// File: rtl/tr_prbs.sv
// Pseudo-random bit source: left-shifting LFSR stepping once per accepted
// sample. A zero seed is replaced by 1. Assumes TAPS gives a usable cycle.
module tr_prbs #(
    parameter int          RW   = 16,
    parameter logic [RW-1:0] TAPS = 16'hB400
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [RW-1:0] seed,
    output logic          rbit
);
    logic [RW-1:0] state;
    logic          fb;

    // Feedback bit from the tapped positions.
    always_comb fb = ^(state & TAPS);

    // Load the seed in reset, otherwise shift on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= (seed == '0) ? RW'(1) : seed;
        end else if (step) begin
            state <= {state[RW-2:0], fb};
        end
    end

    assign rbit = state[0];

    // R8
    prbs_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (state != '0));
endmodule

// File: rtl/tr_sign_sel.sv
// Chooses the sign of the ±1 switching term for odd differences and keeps
// the shaped-mode history. Assumes 'odd' is only meaningful with 'step'.
module tr_sign_sel
    import tr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      step,
    input  logic      odd,
    input  rnd_mode_e mode,
    input  logic      rbit,
    output logic      s_pos
);
    logic have_prev;
    logic prev_pos;

    // Shaped mode alternates once a history exists; else use the random bit.
    always_comb begin
        if (mode == RND_SHAPED && have_prev) s_pos = ~prev_pos;
        else                                 s_pos = rbit;
    end

    // Record the sign of each shaped-mode odd sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_prev <= 1'b0;
            prev_pos  <= 1'b0;
        end else if (step && odd && mode == RND_SHAPED) begin
            have_prev <= 1'b1;
            prev_pos  <= s_pos;
        end
    end
endmodule

// File: rtl/tcode_requant.sv
// Differential thermometer-code requantizer top. Counts both banks,
// subtracts, halves with a ±1 switching term on odd differences, and
// registers the result one cycle after valid_in. Synchronous active-low reset.
module tcode_requant
    import tr_pkg::*;
#(
    parameter  int NCOMP = 32,
    parameter  int RW    = 16,
    localparam int SW    = $clog2(NCOMP + 1) + 1,
    localparam int DW    = SW + 1,
    localparam int YW    = SW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_in,
    input  logic                 shape_en,
    input  logic [RW-1:0]        seed,
    input  logic [NCOMP-1:0]     comp_p,
    input  logic [NCOMP-1:0]     comp_n,
    output logic signed [YW-1:0] y_out,
    output logic                 y_vld
);
    localparam int HALF = NCOMP / 2;

    logic signed [SW-1:0] val_side [2];
    logic signed [DW-1:0] ydiff;
    logic signed [DW-1:0] s_term;
    logic signed [DW-1:0] sum;
    logic signed [YW-1:0] y_next;
    logic signed [DW-1:0] y_x2;
    logic                 rbit;
    logic                 s_pos;
    rnd_mode_e            mode;

    assign mode = rnd_mode_e'(shape_en);

    // One counter per comparator bank.
    for (genvar g = 0; g < 2; g++) begin : g_bank
        tr_bank_count #(.NCOMP(NCOMP), .SW(SW)) u_cnt (
            .therm (g == 0 ? comp_p : comp_n),
            .value (val_side[g])
        );
    end

    tr_prbs #(.RW(RW)) u_prbs (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (valid_in),
        .seed  (seed),
        .rbit  (rbit)
    );

    tr_sign_sel u_sign (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (valid_in),
        .odd   (ydiff[0]),
        .mode  (mode),
        .rbit  (rbit),
        .s_pos (s_pos)
    );

    // Difference, switching term and exact halving.
    always_comb begin
        ydiff  = DW'(val_side[0]) - DW'(val_side[1]);
        s_term = !ydiff[0] ? DW'(0) : (s_pos ? DW'(1) : -DW'(1));
        sum    = ydiff + s_term;
        y_next = YW'(sum >>> 1);
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_out <= '0;
            y_vld <= 1'b0;
        end else begin
            y_vld <= valid_in;
            if (valid_in) y_out <= y_next;
        end
    end

    assign y_x2 = {y_out, 1'b0};

    // R6
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (y_out >= -YW'(HALF)) && (y_out <= YW'(HALF)));
    // R6
    halfstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> (($past(ydiff) - y_x2) >= -DW'(1)) && (($past(ydiff) - y_x2) <= DW'(1)));
    // R3
    even_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !ydiff[0]) |=> (y_x2 == $past(ydiff)));
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(y_out));
    // R7
    vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> y_vld);
endmodule

// File: tb/tcode_requant_bench.sv
module tcode_requant_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCOMP = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              valid_in = 1'b0;
    logic              shape_en = 1'b0;
    logic [15:0]       seed = 16'hACE1;
    logic [NCOMP-1:0]  comp_p = '0;
    logic [NCOMP-1:0]  comp_n = '0;
    logic signed [6:0] y_out;
    logic              y_vld;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    // Reference model state
    logic [15:0] m_lfsr;
    bit          m_have;
    int          m_prev;

    int    exp_q[$];
    string tag_q[$];

    tcode_requant u_tcode_requant (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .shape_en(shape_en),
        .seed(seed), .comp_p(comp_p), .comp_n(comp_n),
        .y_out(y_out), .y_vld(y_vld)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 20000);
            finish_run();
        end
    end

    function automatic logic [NCOMP-1:0] therm(input int k, input bit bubble);
        logic [NCOMP-1:0] v = '0;
        for (int i = 0; i < k; i++) v[i] = 1'b1;
        if (bubble && k >= 1 && k < NCOMP) begin
            v[k-1] = 1'b0;
            v[k]   = 1'b1;
        end
        return v;
    endfunction

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic do_reset(input logic [15:0] sd);
        @(negedge clk);
        valid_in = 1'b0;
        rst_n = 1'b0;
        seed = sd;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 y_out", int'(y_out), 0);
        check("R1 y_vld", int'(y_vld), 0);
        rst_n = 1'b1;
        m_lfsr = (sd == 16'h0) ? 16'h1 : sd;
        m_have = 0;
        m_prev = 0;
    endtask

    // Driver: apply one sample and push its expected result.
    task automatic drive(input int pc, input int nc, input bit shaped,
                         input bit bubble, input string tag);
        int yd, s, y;
        @(negedge clk);
        comp_p = therm(pc, bubble);
        comp_n = therm(nc, bubble);
        shape_en = shaped;
        valid_in = 1'b1;
        yd = (pc - NCOMP/2) - (nc - NCOMP/2);
        s = 0;
        if (yd % 2 != 0) begin
            if (shaped && m_have) s = -m_prev;
            else s = m_lfsr[0] ? 1 : -1;
            if (shaped) begin
                m_have = 1;
                m_prev = s;
            end
        end
        y = (yd + s) / 2;
        m_lfsr = lfsr_next(m_lfsr);
        exp_q.push_back(y);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid_in = 1'b0;
        end
    endtask

    // Monitor: compare each produced result with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && y_vld) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected y_vld", 1, 0);
            end else begin
                check(tag_q.pop_front(), int'(y_out), exp_q.pop_front());
            end
        end
    end

    initial begin
        do_reset(16'hACE1);
        // R2 R3: even differences, clean and bubbled
        drive(16, 16, 0, 0, "R3 zero");
        drive(20, 10, 0, 0, "R3 pos even");
        drive(6, 26, 1, 0, "R3 neg even");
        drive(21, 13, 0, 1, "R2 bubble");
        // R6: extremes
        drive(32, 0, 0, 0, "R6 top");
        drive(0, 32, 0, 0, "R6 bottom");
        // R4: odd differences, white mode
        drive(17, 16, 0, 0, "R4 odd a");
        drive(3, 30, 0, 0, "R4 odd b");
        drive(31, 0, 0, 0, "R4 odd c");
        drive(16, 15, 0, 1, "R4 odd bubble");
        drive(0, 31, 0, 0, "R4 odd d");
        // R5: shaped run, first sign from the generator
        drive(17, 16, 1, 0, "R5 shaped 1");
        drive(18, 10, 1, 0, "R5 shaped even");
        drive(9, 16, 1, 0, "R5 shaped 2");
        drive(25, 2, 1, 0, "R5 shaped 3");
        drive(1, 2, 1, 0, "R5 shaped 4");
        // R9: white odd samples between shaped ones
        drive(15, 16, 0, 0, "R9 white mid a");
        drive(19, 12, 0, 0, "R9 white mid b");
        drive(11, 16, 1, 0, "R9 shaped after white");
        drive(20, 1, 1, 0, "R9 shaped next");
        // R7: hold while idle
        idle(1);
        begin
            int held;
            @(negedge clk);
            held = int'(y_out);
            check("R7 y_vld low", int'(y_vld), 0);
            idle(3);
            check("R7 hold", int'(y_out), held);
        end
        drive(24, 8, 0, 0, "R7 after gap");
        idle(2);
        // R8: zero seed behaves as 1, shaped history cleared by reset
        do_reset(16'h0000);
        drive(17, 16, 0, 0, "R8 zero seed a");
        drive(17, 16, 0, 0, "R8 zero seed b");
        drive(16, 15, 1, 0, "R8 shaped first after reset");
        drive(16, 15, 1, 0, "R8 shaped second");
        idle(3);
        check("R7 queue drained", exp_q.size(), 0);
        done = 1;
        finish_run();
    end
endmodule